// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block keeps the tap position of a 100-step digital potentiometer wiper. It takes a three-pin control port that is asynchronous to the system clock: an active-low select, an active-low step strobe and a direction level. While the block is selected, each high-to-low transition of the strobe moves the position one step. The direction level sampled at that transition sets the way the step goes. The position stops at both ends and never wraps.

The value is driven out both as a binary count and as a one-hot tap-select vector. When select is released, the level of the strobe at that moment decides what happens. If the strobe is high, the position is copied into a stand-in nonvolatile register, and a busy interval of a set number of cycles models the slow write. If the strobe is low, the block just goes back to standby and the new position stays live without being saved. The synchronous reset acts as a power cycle. It reloads the position from the stand-in register, and that register keeps its content across the reset. Its first content comes from a parameter.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `sel_n` is high, transitions on `step_n` and `dir_up` leave `pos` unchanged.
- R2: While selected, each falling edge of `step_n` moves `pos` by one. The step is up when `dir_up` is 1 at that edge and down when it is 0. A change of `dir_up` while `step_n` is already low has no effect.
- R3: `pos` stays within 0 to 99. A step up at 99 holds 99, a step down at 0 holds 0, and a move never changes `pos` by more than one.
- R4: Releasing `sel_n` (low to high) while `step_n` is high starts a save. `busy` rises and stays high for exactly `STORE_CYCLES` cycles. At the end of the save the stand-in register holds the current `pos`.
- R5: Releasing `sel_n` while `step_n` is low saves nothing. `busy` stays low and `pos` keeps its latest value.
- R6: While `busy` is high, activity on `sel_n` and `step_n` is ignored and `pos` does not change.
- R7: Reset loads `pos` from the stand-in register. That register starts at `NV_INIT` and keeps its content across resets.
- R8: `tap_sel` has exactly one bit set, at index `pos`.
- R9: A rising edge of `step_n` never moves `pos`.
- R10: Each control pin passes through a two-flop synchroniser. A step pin edge driven between clock edges shows on `pos` after the third following rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; acts as a power cycle |
| sel_n | input | 1 | Active-low select, asynchronous |
| step_n | input | 1 | Step strobe, moves on its falling edge, asynchronous |
| dir_up | input | 1 | Direction: 1 steps up, 0 steps down, asynchronous |
| pos | output | 7 | Current wiper position, 0 to 99 |
| tap_sel | output | 100 | One-hot tap select, bit `pos` set |
| busy | output | 1 | High while a save is in progress |

## Verification
A wrong position count appears on `pos` and `tap_sel` three clock edges after the strobe edge that caused it. The bench samples exactly there, so an early, late, doubled or reversed step is caught at the strobe that caused it. A save that captures the wrong value, or none, shows only after the next reset, when the recalled position differs. For that reason each release case ends with a reset and a check of the recalled value. A save that runs too long or too short is seen directly as `busy` being wrong on the boundary cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEL   = 2'd1,
        ST_STORE = 2'd2
    } wpc_state_e;

    typedef struct packed {
        logic sel_n;
        logic step_n;
        logic dir_up;
    } wpc_pins_t;

    localparam int PIN_W = $bits(wpc_pins_t);

    // Pin levels assumed at power-up: deselected, strobe high.
    localparam wpc_pins_t PINS_IDLE = '{sel_n: 1'b1, step_n: 1'b1, dir_up: 1'b0};

    // Saturating one-step move between 0 and top.
    function automatic int sat_step(input int cur, input logic up, input int top);
        if (up)
            return (cur >= top) ? top : cur + 1;
        else
            return (cur <= 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
    parameter int                 W       = 3,
    parameter int                 STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int NUM_TAPS     = 100,
    parameter int POS_W        = 7,
    parameter int STORE_CYCLES = 500000,
    parameter int NV_INIT      = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  wpc_pins_t        pins_s,
    output logic [POS_W-1:0] pos,
    output logic             busy
);
    localparam int CNT_W   = $clog2(STORE_CYCLES + 1);
    localparam int TOP_POS = NUM_TAPS - 1;

    wpc_state_e       state;
    logic             step_prev;
    logic [CNT_W-1:0] cnt;
    // Stand-in nonvolatile register: no reset, so it survives a power cycle.
    logic [POS_W-1:0] nv_q = POS_W'(NV_INIT);

    logic step_fall;
    logic save_done;

    assign step_fall = step_prev & ~pins_s.step_n;
    assign save_done = (state == ST_STORE) && (cnt == '0);
    assign busy      = (state == ST_STORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pos       <= nv_q;
            step_prev <= 1'b1;
            cnt       <= '0;
        end else begin
            step_prev <= pins_s.step_n;
            unique case (state)
                ST_IDLE: begin
                    if (!pins_s.sel_n) state <= ST_SEL;
                end
                ST_SEL: begin
                    if (pins_s.sel_n) begin
                        if (pins_s.step_n) begin
                            state <= ST_STORE;
                            cnt   <= CNT_W'(STORE_CYCLES - 1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (step_fall) begin
                        pos <= POS_W'(sat_step(int'(pos), pins_s.dir_up, TOP_POS));
                    end
                end
                ST_STORE: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && save_done) nv_q <= pos;
    end

    // R1: a deselected port never moves the position
    a_r1_hold_deselected: assert property (@(posedge clk) disable iff (rst)
        pins_s.sel_n |=> $stable(pos));

    // R3: the position never jumps by more than one
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pos == $past(pos)) || (pos == $past(pos) + 1'b1) || ($past(pos) == pos + 1'b1));

    // R3: the position stays inside the tap range
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(pos) < NUM_TAPS);

    // R4: the end of a save captures the position
    a_r4_nv_capture: assert property (@(posedge clk) disable iff (rst)
        save_done |=> nv_q == $past(pos));

    // R5: a release with the strobe low never starts a save
    a_r5_no_save: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEL && pins_s.sel_n && !pins_s.step_n) |=> !busy);

    // R6: the position is frozen while busy
    a_r6_busy_freeze: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pos));
endmodule

// File: rtl/wpc_decode.sv
module wpc_decode #(
    parameter int NUM_TAPS = 100,
    parameter int POS_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] tap_sel
);
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_sel[i] = (pos == POS_W'(i));
    end

    // R8: exactly one tap is driven
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1);
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
    import wpc_pkg::*;
#(
    parameter int NUM_TAPS     = 100,
    parameter int SYNC_STAGES  = 2,
    parameter int STORE_CYCLES = 500000,
    parameter int NV_INIT      = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_n,
    input  logic                step_n,
    input  logic                dir_up,
    output logic [6:0]          pos,
    output logic [NUM_TAPS-1:0] tap_sel,
    output logic                busy
);
    localparam int POS_W = $clog2(NUM_TAPS);

    wpc_pins_t        pins_raw;
    wpc_pins_t        pins_s;
    logic [PIN_W-1:0] pins_q;
    logic [POS_W-1:0] pos_i;

    assign pins_raw = '{sel_n: sel_n, step_n: step_n, dir_up: dir_up};

    wpc_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_q)
    );

    assign pins_s = wpc_pins_t'(pins_q);

    wpc_ctrl #(
        .NUM_TAPS     (NUM_TAPS),
        .POS_W        (POS_W),
        .STORE_CYCLES (STORE_CYCLES),
        .NV_INIT      (NV_INIT)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .pins_s (pins_s),
        .pos    (pos_i),
        .busy   (busy)
    );

    wpc_decode #(
        .NUM_TAPS (NUM_TAPS),
        .POS_W    (POS_W)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .pos     (pos_i),
        .tap_sel (tap_sel)
    );

    assign pos = 7'(pos_i);
endmodule

// File: tb/wiper_pos_ctrl_bench.sv
module wiper_pos_ctrl_bench;
    localparam int TAPS   = 100;
    localparam int SAVE_N = 40;
    localparam int INIT   = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sel_n = 1'b1;
    logic            step_n = 1'b1;
    logic            dir_up = 1'b0;
    logic [6:0]      pos;
    logic [TAPS-1:0] tap_sel;
    logic            busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wiper_pos_ctrl #(
        .NUM_TAPS     (TAPS),
        .STORE_CYCLES (SAVE_N),
        .NV_INIT      (INIT)
    ) u_wiper_pos_ctrl (
        .clk     (clk),
        .rst     (rst),
        .sel_n   (sel_n),
        .step_n  (step_n),
        .dir_up  (dir_up),
        .pos     (pos),
        .tap_sel (tap_sel),
        .busy    (busy)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_pos(input string tag, input int exp);
        logic [TAPS-1:0] want;
        want = '0;
        want[exp] = 1'b1;
        chk(tag, int'(pos), exp);
        chk({tag, " R8 tap_sel"}, int'(tap_sel == want), 1);
    endtask

    task automatic pulse(input logic up);
        dir_up = up;
        step_n = 1'b0;
        wait_n(4);
        step_n = 1'b1;
        wait_n(4);
    endtask

    task automatic power_cycle();
        rst    = 1'b1;
        sel_n  = 1'b1;
        step_n = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
    endtask

    task automatic t_reset();
        power_cycle();
        chk_pos("R7 recall of NV_INIT", INIT);
        chk("R4 busy low after reset", int'(busy), 0);
    endtask

    task automatic t_deselected();
        for (int i = 0; i < 3; i++) pulse(1'b1);
        chk_pos("R1 no move while deselected", INIT);
    endtask

    task automatic t_steps();
        sel_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < 4; i++) pulse(1'b1);
        chk_pos("R2 four steps up", 7);
        pulse(1'b0);
        pulse(1'b0);
        chk_pos("R2 two steps down", 5);
        // direction changes while the strobe is already low
        dir_up = 1'b1;
        step_n = 1'b0;
        wait_n(4);
        chk_pos("R2 step uses level at edge", 6);
        dir_up = 1'b0;
        wait_n(4);
        step_n = 1'b1;
        wait_n(4);
        chk_pos("R9 rising edge and late dir change ignored", 6);
    endtask

    task automatic t_latency();
        dir_up = 1'b1;
        step_n = 1'b0;
        wait_n(2);
        chk("R10 no move before third edge", int'(pos), 6);
        wait_n(1);
        chk("R10 move after third edge", int'(pos), 7);
        step_n = 1'b1;
        wait_n(4);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 10; i++) pulse(1'b0);
        chk_pos("R3 hold at zero", 0);
        for (int i = 0; i < 105; i++) pulse(1'b1);
        chk_pos("R3 hold at top", TAPS - 1);
    endtask

    task automatic t_no_save();
        dir_up = 1'b0;
        step_n = 1'b0;
        wait_n(4);
        sel_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wait_n(1);
            chk("R5 busy stays low", int'(busy), 0);
        end
        step_n = 1'b1;
        wait_n(4);
        chk_pos("R5 position kept after release", TAPS - 2);
        power_cycle();
        chk_pos("R7 unsaved move lost on reset", INIT);
    endtask

    task automatic t_save();
        sel_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < 4; i++) pulse(1'b1);
        chk_pos("R4 position before save", INIT + 4);
        sel_n = 1'b1;
        wait_n(2);
        chk("R4 busy not yet high", int'(busy), 0);
        wait_n(1);
        chk("R4 busy rises", int'(busy), 1);
        // activity during the save must be ignored (R6)
        sel_n  = 1'b0;
        dir_up = 1'b1;
        step_n = 1'b0;
        wait_n(4);
        step_n = 1'b1;
        wait_n(4);
        step_n = 1'b0;
        wait_n(4);
        step_n = 1'b1;
        sel_n  = 1'b1;
        wait_n(4);
        chk_pos("R6 no move while busy", INIT + 4);
        wait_n(SAVE_N - 1 - 16);
        chk("R4 busy on last cycle", int'(busy), 1);
        wait_n(1);
        chk("R4 busy falls after STORE_CYCLES", int'(busy), 0);
        chk_pos("R6 position after save", INIT + 4);
        power_cycle();
        chk_pos("R7 saved value recalled", INIT + 4);
    endtask

    initial begin
        t_reset();
        t_deselected();
        t_steps();
        t_latency();
        t_saturate();
        t_no_save();
        t_save();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule